// File: doc/BRIEF.md
# Per-Core Local Interrupt Aggregator

This block gathers the interrupt sources local to each core of a small cluster and turns them into one level-sensitive IRQ line per core. Each core sees a pending word assembled from seven kinds of source: four generic-timer lines, a mailbox summary line, a peripheral-controller line shared by the cluster, and a performance-monitor line. A pending bit is set only while its raw source is active and software has enabled or routed that source to the core. The word has no latch. It follows the sources in the same cycle. The core's IRQ is the OR of the word.

Software reaches the block through a simple register bus. Each core has its own timer-enable and mailbox-enable registers, and these sit at a 4-byte stride. The performance-monitor routing mask changes only through a pair of registers: one sets mask bits and the other clears them. Each core has a read-only pending register at a 4-byte stride. An interrupt handler reads its core's pending register and services the lowest set bit first.

Address map, byte offsets on `busAddr`: routing-set at 0x00, routing-clear at 0x04, timer-enable for core c at 0x20+4c, mailbox-enable for core c at 0x40+4c, pending for core c at 0x60+4c.

Top module: `irq_local_agg`

## Requirements
- R1: After reset every enable register and the routing mask read as zero, and every `coreIrq` output stays low even when all timer, mailbox and performance-monitor sources are active.
- R2: A write to a core's timer-enable register (0x20+4c) stores bits 3:0 only. A read returns those four bits with all upper bits zero.
- R3: A write to a core's mailbox-enable register (0x40+4c) stores bit 0 only. A read returns that bit with all upper bits zero.
- R4: A write to routing-set (0x00) sets routing-mask bit n for every 1 in bit n of the write data and leaves the 0 bits unchanged. Reads at 0x00 or 0x04 return the current mask.
- R5: A write to routing-clear (0x04) clears routing-mask bit n for every 1 in bit n of the write data and leaves the 0 bits unchanged.
- R6: Pending bits 3:0 of core c equal its timer lines `timerIrq[4c+3:4c]` ANDed with that core's timer-enable bits. The lines are ordered secure physical, non-secure physical, hypervisor, virtual.
- R7: Pending bit 4 of core c equals `mboxPend[c]` ANDed with that core's mailbox-enable bit 0.
- R8: Pending bit 8 of core 0 equals `periphIrq`, with no enable. `periphIrq` never sets a pending bit of any other core.
- R9: Pending bit 9 of core c equals `pmuIrq[c]` ANDed with routing-mask bit c.
- R10: The pending registers (0x60+4c) follow the sources in the same cycle with no latching, and writes to them have no effect.
- R11: `coreIrq[c]` is high exactly when the pending word of core c is nonzero.
- R12: Reads of unmapped offsets, and of per-core registers whose core index is at or above the core count, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for `busAddr`, combinational |
| timerIrq | input | 4*NUM_CORES | Raw timer lines, four per core, core c at bits 4c+3:4c |
| mboxPend | input | NUM_CORES | Mailbox-pending summary, one per core |
| periphIrq | input | 1 | Shared peripheral-controller line |
| pmuIrq | input | NUM_CORES | Performance-monitor line, one per core |
| coreIrq | output | NUM_CORES | IRQ to each core |

## Verification
A register write takes effect at the clock edge that samples `busWr`. A read or IRQ that depends on the new value is therefore due in the following cycle. The bench drives each write in one low clock phase, lets a rising edge pass, and reads in the next low phase. Pending words, `coreIrq` and read data react to source changes in the same cycle with no register on the path. The bench samples these a short settle delay after it changes the inputs, and it does so at a falling edge, away from any clock edge.

// File: rtl/irq_local_agg_pkg.sv
package irq_local_agg_pkg;
  localparam int TIMER_LINES = 4;
  localparam int CORE_IDX_W  = 3;   // per-core index field of the address: up to 8 cores
  localparam int PB_MBOX     = 4;
  localparam int PB_PERIPH   = 8;
  localparam int PB_PMU      = 9;

  localparam logic [7:0] OFS_ROUTE_SET = 8'h00;
  localparam logic [7:0] OFS_ROUTE_CLR = 8'h04;
  localparam logic [7:0] OFS_TIMER     = 8'h20;
  localparam logic [7:0] OFS_MBOX      = 8'h40;
  localparam logic [7:0] OFS_PEND      = 8'h60;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_TIMER,
    RD_MBOX,
    RD_ROUTE,
    RD_PEND
  } rd_kind_e;

  typedef struct packed {
    logic                  wrTimer;
    logic                  wrMbox;
    logic                  wrSet;
    logic                  wrClr;
    rd_kind_e              rdKind;
    logic [CORE_IDX_W-1:0] core;
  } agg_strobe_t;
endpackage

// File: rtl/irq_local_agg_ctrl.sv
module irq_local_agg_ctrl
  import irq_local_agg_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output agg_strobe_t       strobe
);
  logic       hiZero;
  logic [1:0] bank;
  logic [CORE_IDX_W-1:0] idx;
  logic       coreOk;
  logic       lowOk;

  always_comb begin
    hiZero = (busAddr >> 7) == '0;
    lowOk  = busAddr[1:0] == 2'b00;
    bank   = busAddr[6:5];
    idx    = busAddr[4:2];
    coreOk = 32'(idx) < NUM_CORES;

    strobe        = '0;
    strobe.rdKind = RD_NONE;
    strobe.core   = idx;

    if (hiZero && lowOk) begin
      unique case (bank)
        2'd0: begin
          if (idx == CORE_IDX_W'(0)) begin
            strobe.wrSet  = busWr;
            strobe.rdKind = RD_ROUTE;
          end else if (idx == CORE_IDX_W'(1)) begin
            strobe.wrClr  = busWr;
            strobe.rdKind = RD_ROUTE;
          end
        end
        2'd1: if (coreOk) begin
          strobe.wrTimer = busWr;
          strobe.rdKind  = RD_TIMER;
        end
        2'd2: if (coreOk) begin
          strobe.wrMbox = busWr;
          strobe.rdKind = RD_MBOX;
        end
        2'd3: if (coreOk) begin
          strobe.rdKind = RD_PEND;     // read-only: write strobe never raised
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_local_agg_dp.sv
module irq_local_agg_dp
  import irq_local_agg_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  agg_strobe_t                        strobe,
  input  logic [DATA_W-1:0]                  busWdata,
  output logic [DATA_W-1:0]                  busRdata,
  input  logic [TIMER_LINES*NUM_CORES-1:0]   timerIrq,
  input  logic [NUM_CORES-1:0]               mboxPend,
  input  logic                               periphIrq,
  input  logic [NUM_CORES-1:0]               pmuIrq,
  output logic [NUM_CORES-1:0]               coreIrq
);
  logic [NUM_CORES-1:0][TIMER_LINES-1:0] timerEn;
  logic [NUM_CORES-1:0]                  mboxEn;
  logic [NUM_CORES-1:0]                  routeMask;
  logic [NUM_CORES-1:0][DATA_W-1:0]      pendWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerEn   <= '0;
      mboxEn    <= '0;
      routeMask <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (strobe.wrTimer && strobe.core == CORE_IDX_W'(c))
          timerEn[c] <= busWdata[TIMER_LINES-1:0];
        if (strobe.wrMbox && strobe.core == CORE_IDX_W'(c))
          mboxEn[c] <= busWdata[0];
      end
      if (strobe.wrSet)
        routeMask <= routeMask | busWdata[NUM_CORES-1:0];
      else if (strobe.wrClr)
        routeMask <= routeMask & ~busWdata[NUM_CORES-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic periphHere;
    if (c == 0) begin : g_periph
      assign periphHere = periphIrq;
    end else begin : g_noperiph
      assign periphHere = 1'b0;
    end

    always_comb begin
      pendWord[c] = '0;
      pendWord[c][TIMER_LINES-1:0] = timerIrq[c*TIMER_LINES +: TIMER_LINES] & timerEn[c];
      pendWord[c][PB_MBOX]   = mboxPend[c] & mboxEn[c];
      pendWord[c][PB_PERIPH] = periphHere;
      pendWord[c][PB_PMU]    = pmuIrq[c] & routeMask[c];
    end

    assign coreIrq[c] = |pendWord[c];
  end

  always_comb begin
    busRdata = '0;
    unique case (strobe.rdKind)
      RD_ROUTE: busRdata = DATA_W'(routeMask);
      RD_TIMER, RD_MBOX, RD_PEND: begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (strobe.core == CORE_IDX_W'(c)) begin
            if (strobe.rdKind == RD_TIMER)     busRdata = DATA_W'(timerEn[c]);
            else if (strobe.rdKind == RD_MBOX) busRdata = DATA_W'(mboxEn[c]);
            else                               busRdata = pendWord[c];
          end
        end
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_local_agg.sv
module irq_local_agg
  import irq_local_agg_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic                             busWr,
  input  logic [DATA_W-1:0]                busWdata,
  output logic [DATA_W-1:0]                busRdata,
  input  logic [TIMER_LINES*NUM_CORES-1:0] timerIrq,
  input  logic [NUM_CORES-1:0]             mboxPend,
  input  logic                             periphIrq,
  input  logic [NUM_CORES-1:0]             pmuIrq,
  output logic [NUM_CORES-1:0]             coreIrq
);
  agg_strobe_t strobe;

  irq_local_agg_ctrl #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobe  (strobe)
  );

  irq_local_agg_dp #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .timerIrq  (timerIrq),
    .mboxPend  (mboxPend),
    .periphIrq (periphIrq),
    .pmuIrq    (pmuIrq),
    .coreIrq   (coreIrq)
  );
endmodule

// File: rtl/irq_local_agg_chk.sv
module irq_local_agg_chk
  import irq_local_agg_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [ADDR_W-1:0]                busAddr,
  input logic                             busWr,
  input logic [DATA_W-1:0]                busWdata,
  input logic [DATA_W-1:0]                busRdata,
  input logic [TIMER_LINES*NUM_CORES-1:0] timerIrq,
  input logic [NUM_CORES-1:0]             mboxPend,
  input logic                             periphIrq,
  input logic [NUM_CORES-1:0]             pmuIrq,
  input logic [NUM_CORES-1:0]             coreIrq
);
  AST_PERIPH_TO_CORE0: assert property (@(posedge clk) disable iff (!rstN)
    periphIrq |-> coreIrq[0]); // R8

  AST_QUIET_WITHOUT_SOURCES: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq == '0 && mboxPend == '0 && !periphIrq && pmuIrq == '0) |-> coreIrq == '0); // R11

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    AST_SET_ROUTES_PMU: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ADDR_W'(OFS_ROUTE_SET) && busWdata[c]) |=> (!pmuIrq[c] || coreIrq[c])); // R4

    AST_CLR_DROPS_PMU: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == ADDR_W'(OFS_ROUTE_CLR) && busWdata[c])
        |=> ((timerIrq[c*TIMER_LINES +: TIMER_LINES] != '0) || mboxPend[c]
             || (c == 0 && periphIrq) || !coreIrq[c])); // R5

    AST_PEND_READ_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
      (busAddr == ADDR_W'(OFS_PEND + 8'(4*c))) |-> ((busRdata != '0) == coreIrq[c])); // R11
  end
endmodule

bind irq_local_agg irq_local_agg_chk #(
  .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .busRdata(busRdata), .timerIrq(timerIrq), .mboxPend(mboxPend),
  .periphIrq(periphIrq), .pmuIrq(pmuIrq), .coreIrq(coreIrq)
);

// File: tb/tb_irq_local_agg.sv
`timescale 1ns/1ps
module tb_irq_local_agg;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWr = 1'b0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [4*NC-1:0] timerIrq = '0;
  logic [NC-1:0] mboxPend = '0;
  logic          periphIrq = 1'b0;
  logic [NC-1:0] pmuIrq = '0;
  logic [NC-1:0] coreIrq;

  int checks = 0;
  int errors = 0;
  logic [NC-1:0][3:0] mTimer;
  logic [NC-1:0]      mMbox;
  logic [NC-1:0]      mRoute;

  always #2.5 clk = ~clk;

  irq_local_agg #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  // {timerIrq, mboxPend, periphIrq, pmuIrq, expected coreIrq}
  typedef struct packed {
    logic [15:0] t;
    logic [3:0]  m;
    logic        p;
    logic [3:0]  u;
    logic [3:0]  irq;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 4'b0000, 1'b0, 4'b0000, 4'b0000},
    '{16'h0001, 4'b0000, 1'b0, 4'b0000, 4'b0001},
    '{16'h0002, 4'b0000, 1'b0, 4'b0000, 4'b0000},
    '{16'h00A0, 4'b0000, 1'b0, 4'b0000, 4'b0010},
    '{16'h0050, 4'b0000, 1'b0, 4'b0000, 4'b0000},
    '{16'hF000, 4'b0000, 1'b0, 4'b0000, 4'b0000},
    '{16'h0800, 4'b0000, 1'b0, 4'b0000, 4'b0100},
    '{16'h0000, 4'b1111, 1'b0, 4'b0000, 4'b1010},
    '{16'h0000, 4'b0000, 1'b1, 4'b0000, 4'b0001},
    '{16'h0000, 4'b0000, 1'b0, 4'b1111, 4'b0101},
    '{16'h0000, 4'b0000, 1'b0, 4'b1010, 4'b0000},
    '{16'h0001, 4'b0010, 1'b0, 4'b0000, 4'b0011}
  };

  function automatic logic [DW-1:0] expPend(int c);
    logic [DW-1:0] w = '0;
    w[3:0] = timerIrq[4*c +: 4] & mTimer[c];
    w[4]   = mboxPend[c] & mMbox[c];
    w[8]   = (c == 0) ? periphIrq : 1'b0;
    w[9]   = pmuIrq[c] & mRoute[c];
    return w;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic checkPendAll(string req);
    logic [DW-1:0] d;
    for (int c = 0; c < NC; c++) begin
      rd(AW'(8'h60 + 8'(4*c)), d);
      check(req, d, expPend(c));
      check("R11", DW'(coreIrq[c]), DW'(expPend(c) != '0));
    end
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    mTimer = '0; mMbox = '0; mRoute = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, sources active but nothing enabled
    timerIrq = '1; mboxPend = '1; pmuIrq = '1;
    for (int c = 0; c < NC; c++) begin
      rd(AW'(8'h20 + 8'(4*c)), d); check("R1 timer", d, '0);
      rd(AW'(8'h40 + 8'(4*c)), d); check("R1 mbox", d, '0);
    end
    rd(8'h00, d); check("R1 route", d, '0);
    check("R1 irq", DW'(coreIrq), '0);
    timerIrq = '0; mboxPend = '0; pmuIrq = '0;

    // R2, R3: stored widths
    wr(8'h24, 32'hFFFF_FFF5); rd(8'h24, d); check("R2", d, 32'h5);
    wr(8'h44, 32'hFFFF_FFFE); rd(8'h44, d); check("R3 bit0 clear", d, 32'h0);
    wr(8'h44, 32'h0000_0003); rd(8'h44, d); check("R3 bit0 set", d, 32'h1);

    // R4, R5: set/clear semantics
    wr(8'h00, 32'h5); rd(8'h00, d); check("R4 set", d, 32'h5);
    wr(8'h00, 32'h0); rd(8'h04, d); check("R4 zero write", d, 32'h5);
    wr(8'h00, 32'h2); rd(8'h00, d); check("R4 accumulate", d, 32'h7);
    wr(8'h04, 32'h2); rd(8'h00, d); check("R5 clear", d, 32'h5);
    wr(8'h04, 32'h0); rd(8'h04, d); check("R5 zero write", d, 32'h5);

    // configuration for the vector table
    wr(8'h20, 32'h1); wr(8'h24, 32'hA); wr(8'h28, 32'hF); wr(8'h2C, 32'h0);
    wr(8'h40, 32'h0); wr(8'h44, 32'h1); wr(8'h48, 32'h0); wr(8'h4C, 32'h1);
    mTimer[0] = 4'h1; mTimer[1] = 4'hA; mTimer[2] = 4'hF; mTimer[3] = 4'h0;
    mMbox = 4'b1010; mRoute = 4'b0101;

    // R6 R7 R8 R9 R10 R11: vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      timerIrq = VECS[i].t; mboxPend = VECS[i].m; periphIrq = VECS[i].p; pmuIrq = VECS[i].u;
      #1 check("R11 vector irq", DW'(coreIrq), DW'(VECS[i].irq));
      checkPendAll("R6 R7 R8 R9 R10 pending");
    end

    // R10: pending is combinational and read-only
    @(negedge clk);
    timerIrq = 16'h0001; mboxPend = '0; periphIrq = 1'b1; pmuIrq = 4'b0001;
    #1 busAddr = 8'h60;
    #0.5 check("R10 same cycle", busRdata, 32'h0000_0301);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h64, 32'h0);
    rd(8'h20, d); check("R10 write ignored timer", d, 32'h1);
    rd(8'h00, d); check("R10 write ignored route", d, 32'h5);
    checkPendAll("R10 pending after write");

    // R8: peripheral line never reaches other cores
    timerIrq = '0; pmuIrq = '0; periphIrq = 1'b1;
    #1 check("R8 core0 only", DW'(coreIrq), 32'h1);
    periphIrq = 1'b0;

    // R9: clearing route removes pmu pending
    pmuIrq = 4'b0101;
    wr(8'h04, 32'h1); mRoute = 4'b0100;
    #1 check("R9 unrouted", DW'(coreIrq), 32'h4);
    checkPendAll("R9 pending");

    // R12: unmapped and out-of-range
    rd(8'h1C, d); check("R12 unmapped", d, '0);
    rd(8'h08, d); check("R12 bank0 gap", d, '0);
    rd(AW'(8'h20 + 8'(4*5)), d); check("R12 core index high timer", d, '0);
    rd(AW'(8'h60 + 8'(4*6)), d); check("R12 core index high pend", d, '0);
    rd(8'h81, d); check("R12 above map", d, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule